// File: doc/BRIEF.md
# Charge Pump Gain Mode Sequencer

This block chooses the gain of an LED charge pump. The three settings are pass-through (1x), 1.5x and 2x. The LED current sources report dropout. When a report holds for a full qualification window, the sequencer moves the pump up by one gain step. After each step-up it raises the pump drive strength linearly from zero, which acts as a soft start. The gain can only rise. It falls back to 1x only when shutdown is asserted or when the flash-channel enable has a falling edge.

In 1x the supply is passed straight to the output through bypass switches. These switches close only after an external comparator reports that the output has decayed to the supply level or below. Once closed, they stay closed for the rest of that 1x stay. A thermal fault turns off the pump, the bypass switches and the current sources for as long as the fault flag is set.

Top module: `cp_mode_seq`

## Requirements
- R1: After reset, mode_o is 1x (code 0), strength_o is 0, pump_en_o and bypass_o are 0, and src_en_o is 1 unless shutdown or the thermal fault is set.
- R2: Mode codes are 0 = 1x, 1 = 1.5x and 2 = 2x. A qualified dropout moves the mode exactly one step up, from 0 to 1 or from 1 to 2.
- R3: dropout_i must be high for QUAL_CYCLES consecutive clock edges before a step is taken. If it goes low, the count restarts from zero.
- R4: strength_o clears on every mode change, during shutdown and during a thermal fault. Otherwise, while the mode is not 1x, it rises by 1 every RAMP_DIV cycles and saturates at 2**RAMP_W-1.
- R5: shdn_i forces the mode to 1x on the next edge, clears the qualification and turns off src_en_o and pump_en_o.
- R6: A falling edge of flash_en_i returns the mode to 1x on the next edge. A rising edge, or flash_en_i held low, has no effect on the mode.
- R7: 2x is terminal. Dropout in 2x leaves the mode unchanged.
- R8: bypass_o is high only in 1x. It first goes high one edge after out_le_sup_i is seen high. It then stays high while in 1x, even if out_le_sup_i drops.
- R9: therm_fault_i forces pump_en_o, src_en_o and bypass_o low and keeps the current mode. When the flag clears, the outputs are enabled again.
- R10: pump_en_o is high when the mode is not 1x and neither shutdown nor the thermal fault is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dropout_i | input | 1 | Dropout report from the LED current sources |
| flash_en_i | input | 1 | Flash-channel enable; its falling edge resets the mode |
| shdn_i | input | 1 | Shutdown request |
| therm_fault_i | input | 1 | Over-temperature flag |
| out_le_sup_i | input | 1 | Comparator flag: output at or below the supply |
| mode_o | output | 2 | Gain mode code (0 = 1x, 1 = 1.5x, 2 = 2x) |
| strength_o | output | RAMP_W | Pump strength ramp value |
| pump_en_o | output | 1 | Pump switching enable |
| bypass_o | output | 1 | 1x bypass switch enable |
| src_en_o | output | 1 | LED current source enable |

## Verification
The bench builds the block with QUAL_CYCLES=4, RAMP_W=3 and RAMP_DIV=2. With these values an interrupted dropout run, a full qualification and the terminal 2x state each take only a few cycles. The whole soft-start ramp up to its saturation at 7 fits in 14 cycles, so the ramp can be traced step by step and the saturated value held afterwards. The default window of 0.4 ms and the default ramp of about 150 µs are the same counters with larger limits.

// File: rtl/cp_mode_pkg.sv
package cp_mode_pkg;
  typedef logic [1:0] mode_t;
  localparam mode_t MODE_1X   = 2'd0;
  localparam mode_t MODE_1P5X = 2'd1;
  localparam mode_t MODE_2X   = 2'd2;
endpackage

// File: rtl/cp_dropout_qual.sv
module cp_dropout_qual #(
  parameter int unsigned QUAL_CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic drop_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = drop_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || !drop_i || hit_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  // R3: a qualified hit needs dropout already present on the previous edge
  a_r3_hit_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(drop_i));
  // R3: a low dropout restarts the window
  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drop_i |=> cnt_q == '0);
endmodule

// File: rtl/cp_soft_ramp.sv
module cp_soft_ramp #(
  parameter int unsigned RAMP_W   = 6,
  parameter int unsigned RAMP_DIV = 117
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  output logic [RAMP_W-1:0] level_o
);
  localparam int unsigned PW = $clog2(RAMP_DIV + 1);
  localparam logic [PW-1:0] PLAST = PW'(RAMP_DIV - 1);
  localparam logic [RAMP_W-1:0] FULL = '1;

  logic [PW-1:0]     pre_q;
  logic [RAMP_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      lvl_q <= '0;
    end else if (run_i && lvl_q != FULL) begin
      if (pre_q == PLAST) begin
        pre_q <= '0;
        lvl_q <= lvl_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;

  // R4: saturation holds
  a_r4_ramp_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && lvl_q == FULL) |=> lvl_q == FULL);
  // R4: ramp is linear, never jumps by more than one
  a_r4_ramp_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (lvl_q == $past(lvl_q) || lvl_q == RAMP_W'($past(lvl_q) + 1'b1)));
endmodule

// File: rtl/cp_mode_seq.sv
module cp_mode_seq
  import cp_mode_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 20000,
  parameter int unsigned RAMP_W      = 6,
  parameter int unsigned RAMP_DIV    = 117
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dropout_i,
  input  logic              flash_en_i,
  input  logic              shdn_i,
  input  logic              therm_fault_i,
  input  logic              out_le_sup_i,
  output logic [1:0]        mode_o,
  output logic [RAMP_W-1:0] strength_o,
  output logic              pump_en_o,
  output logic              bypass_o,
  output logic              src_en_o
);
  mode_t mode_q;
  logic  flash_q, byp_ok_q;
  logic  flash_fall, back_1x, step, qual_clr, active;

  assign flash_fall = flash_q && !flash_en_i;
  assign back_1x    = shdn_i || flash_fall;
  assign active     = !shdn_i && !therm_fault_i;
  assign qual_clr   = back_1x || therm_fault_i || (mode_q == MODE_2X);

  cp_dropout_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (qual_clr),
    .drop_i (dropout_i),
    .hit_o  (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flash_q <= 1'b0;
      mode_q  <= MODE_1X;
    end else begin
      flash_q <= flash_en_i;
      if (back_1x)   mode_q <= MODE_1X;
      else if (step) mode_q <= (mode_q == MODE_1X) ? MODE_1P5X : MODE_2X;
    end
  end

  // bypass held off until the output has decayed to the supply
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   byp_ok_q <= 1'b0;
    else if (shdn_i || step || mode_q != MODE_1X)   byp_ok_q <= 1'b0;
    else if (out_le_sup_i)                          byp_ok_q <= 1'b1;
  end

  cp_soft_ramp #(.RAMP_W(RAMP_W), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (back_1x || step || therm_fault_i),
    .run_i   (mode_q != MODE_1X),
    .level_o (strength_o)
  );

  assign mode_o    = mode_q;
  assign src_en_o  = active;
  assign pump_en_o = active && (mode_q != MODE_1X);
  assign bypass_o  = active && (mode_q == MODE_1X) && byp_ok_q;

  // R2: any change not caused by a reset is a single step up
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q) && !$past(back_1x)) |-> mode_q == mode_t'($past(mode_q) + 2'd1));
  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3);
  // R5: shutdown returns to 1x
  a_r5_shdn_1x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> mode_q == MODE_1X);
  // R6: flash enable falling edge returns to 1x
  a_r6_fall_1x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flash_en_i) && !flash_en_i) |=> mode_q == MODE_1X);
  // R7: 2x is held until a reset to 1x
  a_r7_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_2X && !back_1x) |=> mode_q == MODE_2X);
  // R8: bypass closes only after the comparator has reported in 1x
  a_r8_byp_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bypass_o) |-> ($past(out_le_sup_i) || $past(bypass_o) == 1'b0 && $past(byp_ok_q)));
  // R9: thermal fault keeps the mode
  a_r9_fault_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_fault_i && !back_1x) |=> $stable(mode_q));
endmodule

// File: tb/tb_cp_mode_seq.sv
module tb_cp_mode_seq;
  localparam int unsigned QC = 4;
  localparam int unsigned RW = 3;
  localparam int unsigned RD = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic drop = 1'b0, flash = 1'b0, shdn = 1'b0, therm = 1'b0, cmp = 1'b0;
  logic [1:0] mode;
  logic [RW-1:0] str;
  logic pump, byp, src;
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  cp_mode_seq #(.QUAL_CYCLES(QC), .RAMP_W(RW), .RAMP_DIV(RD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dropout_i(drop), .flash_en_i(flash),
    .shdn_i(shdn), .therm_fault_i(therm), .out_le_sup_i(cmp),
    .mode_o(mode), .strength_o(str), .pump_en_o(pump), .bypass_o(byp), .src_en_o(src)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // {shdn,flash,drop,therm,cmp}, hold edges, mode, pump, src
  localparam logic [16:0] VEC [16] = '{
    {5'b01000, 8'd3,  2'd0, 1'b0, 1'b1},  // R1 idle
    {5'b01100, 8'd3,  2'd0, 1'b0, 1'b1},  // R3 short run
    {5'b01000, 8'd1,  2'd0, 1'b0, 1'b1},  // R3 gap
    {5'b01100, 8'd3,  2'd0, 1'b0, 1'b1},  // R3 restarted
    {5'b01100, 8'd1,  2'd1, 1'b1, 1'b1},  // R2 step to 1.5x
    {5'b01100, 8'd3,  2'd1, 1'b1, 1'b1},  // R3
    {5'b01100, 8'd1,  2'd2, 1'b1, 1'b1},  // R2 step to 2x
    {5'b01100, 8'd10, 2'd2, 1'b1, 1'b1},  // R7 terminal
    {5'b00000, 8'd1,  2'd0, 1'b0, 1'b1},  // R6 falling edge
    {5'b00100, 8'd4,  2'd1, 1'b1, 1'b1},  // R6 low level no reset
    {5'b01000, 8'd2,  2'd1, 1'b1, 1'b1},  // R6 rising edge no effect
    {5'b11000, 8'd1,  2'd0, 1'b0, 1'b0},  // R5 shutdown
    {5'b11100, 8'd6,  2'd0, 1'b0, 1'b0},  // R5 no qual in shutdown
    {5'b01100, 8'd4,  2'd1, 1'b1, 1'b1},  // R10 pump on
    {5'b01010, 8'd2,  2'd1, 1'b0, 1'b0},  // R9 fault
    {5'b01000, 8'd2,  2'd1, 1'b1, 1'b1}   // R9 recovery
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    edges(3);
    rst_ni = 1'b1;
    edges(1);
    check("R1 mode", mode, 0);
    check("R1 strength", str, 0);
    check("R1 pump", pump, 0);
    check("R1 bypass", byp, 0);
    check("R1 src", src, 1);

    for (int i = 0; i < 16; i++) begin
      {shdn, flash, drop, therm, cmp} = VEC[i][16:12];
      edges(int'(VEC[i][11:4]));
      check($sformatf("R2 vec%0d mode", i), mode, int'(VEC[i][3:2]));
      check($sformatf("R10 vec%0d pump", i), pump, int'(VEC[i][1]));
      check($sformatf("R9 vec%0d src", i), src, int'(VEC[i][0]));
    end

    // R4 soft-start ramp
    shdn = 1'b1; drop = 1'b0; edges(1);
    check("R4 shdn clears ramp", str, 0);
    shdn = 1'b0; drop = 1'b1; edges(QC);
    drop = 1'b0;
    check("R4 step mode", mode, 1);
    check("R4 ramp starts at zero", str, 0);
    edges(2);
    check("R4 first increment", str, 1);
    edges(12);
    check("R4 full", str, 7);
    edges(6);
    check("R4 saturated", str, 7);
    drop = 1'b1; edges(QC);
    drop = 1'b0;
    check("R7 mode 2x", mode, 2);
    check("R4 cleared on step", str, 0);

    // R8 bypass hold-off
    flash = 1'b0; cmp = 1'b0; edges(1);
    check("R6 back to 1x", mode, 0);
    edges(3);
    check("R8 held off", byp, 0);
    cmp = 1'b1; edges(1);
    check("R8 closes", byp, 1);
    cmp = 1'b0; edges(2);
    check("R8 stays closed", byp, 1);
    check("R10 pump off in 1x", pump, 0);
    flash = 1'b1; drop = 1'b1; edges(QC);
    drop = 1'b0;
    check("R8 open in 1.5x", byp, 0);
    check("R2 mode", mode, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule